// File: doc/BRIEF.md
# Elastic Single-Bit Predicate Switch Tile

This tile is one node of a dedicated single-bit predicate fabric that sits beside a word-wide data array. It receives predicate tokens on four edge ports (north, east, south, west) and one local port, steers each token to any set of output ports through an orthogonal-only switch, and can combine two tokens with a small logic unit (AND, OR, XOR or pass-through). Tiles abut edge to edge, so a predicate can travel across any number of tiles from the unit that makes it to the unit that uses it.

Every transfer follows a valid/stop handshake, so predicate tokens stay in step with the data events they govern. A source that feeds several outputs is held until every enabled destination has taken its copy, and each output is registered through a one-entry elastic buffer. Routing and the logic operation come from static configuration inputs that are held constant while tokens flow.

Port index order for every 5-bit handshake vector: bit 0 north, bit 1 east, bit 2 south, bit 3 west, bit 4 local.

Top module: `pred_tile`

## Requirements
- R1: While reset is high and in the first cycle after it, all `out_valid` bits are 0 and, with no input valid, all `in_stop` bits are 0.
- R2: Output port p takes its source from `cfg_route[4p+3:4p]`: 1 north, 2 east, 3 south, 4 west, 5 local input, 6 logic unit result. A token accepted at an input on a clock edge appears at the selected output after that edge, with its bit unchanged.
- R3: A route code of 0, any code from 7 to 15, and a code that selects the output's own direction (a U-turn) disable the output; it never becomes valid. An input token with no enabled destination is accepted and discarded (its `in_stop` stays 0).
- R4: The logic unit result is A AND B for `cfg_op` 0, A OR B for 1, A XOR B for 2 and A for 3. Operand selects `cfg_opa`/`cfg_opb` use 0 off, 1 north, 2 east, 3 south, 4 west, 5 local input.
- R5: The logic unit fires only when both operands are valid and its result buffer can accept; a lone operand is held (its `in_stop` is 1). The result reaches an output two clock edges after the operands are accepted, never after one.
- R6: A source feeding several outputs keeps its `in_stop` high until every enabled destination has accepted the token; a destination that already accepted does not receive a second copy.
- R7: While an output is valid and stopped, its `out_valid` stays 1 and `out_data` stays unchanged; when its buffer is full and stopped, a source feeding it sees `in_stop` high.
- R8: With `out_stop` low, a routed path carries one token per clock cycle without bubbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_route | input | 20 | Per-output 4-bit source codes, output p at bits 4p+3:4p |
| cfg_opa | input | 3 | Logic unit operand A source |
| cfg_opb | input | 3 | Logic unit operand B source |
| cfg_op | input | 2 | Logic unit operation |
| in_valid | input | 5 | Incoming token valid per port |
| in_data | input | 5 | Incoming predicate bit per port |
| in_stop | output | 5 | Back-pressure to each upstream port |
| out_valid | output | 5 | Outgoing token valid per port |
| out_data | output | 5 | Outgoing predicate bit per port |
| out_stop | input | 5 | Back-pressure from each downstream port |

## Verification
A corrupted fork completion flag shows at once as a duplicate token on an output that already accepted, or as an input `in_stop` that never drops, within one or two cycles of a partial stall. A wrong route decode shows on the very next edge as a token on a disabled or U-turn output, or a missing token on an enabled one, and the exhaustive route sweep catches it for every code. A logic unit fault appears two edges after the operands as a wrong result bit across the full sweep of operand sources, operations and input patterns, while an early-fire fault shows as a result one edge too soon or with only one operand present.

// File: rtl/pred_pkg.sv
package pred_pkg;

    localparam int NDIR     = 4;
    localparam int NPORT    = NDIR + 1;
    localparam int LOC_IDX  = NDIR;
    localparam int NSRC     = NPORT + 1;
    localparam int LU_IDX   = NPORT;
    localparam int NDST     = NPORT + 2;
    localparam int OPA_IDX  = NPORT;
    localparam int OPB_IDX  = NPORT + 1;
    localparam int ROUTE_W  = 4;
    localparam int OPSEL_W  = 3;

    typedef enum logic [1:0] {
        OP_AND  = 2'd0,
        OP_OR   = 2'd1,
        OP_XOR  = 2'd2,
        OP_PASS = 2'd3
    } pred_op_e;

    function automatic logic pred_eval(input logic [1:0] op, input logic a, input logic b);
        logic r;
        case (pred_op_e'(op))
            OP_AND:  r = a & b;
            OP_OR:   r = a | b;
            OP_XOR:  r = a ^ b;
            default: r = a;
        endcase
        return r;
    endfunction

    // One-hot source vector for an output port; zero when disabled.
    function automatic logic [NSRC-1:0] route_onehot(input logic [ROUTE_W-1:0] code,
                                                     input int port);
        logic [NSRC-1:0] r;
        int idx;
        r = '0;
        if (code >= ROUTE_W'(1) && code <= ROUTE_W'(NSRC)) begin
            idx = int'(code) - 1;
            if (!(idx < NDIR && idx == port))
                r[idx] = 1'b1;
        end
        return r;
    endfunction

    // One-hot source vector for a logic unit operand; inputs only.
    function automatic logic [NSRC-1:0] opnd_onehot(input logic [OPSEL_W-1:0] sel);
        logic [NSRC-1:0] r;
        r = '0;
        if (sel >= OPSEL_W'(1) && sel <= OPSEL_W'(NPORT))
            r[int'(sel) - 1] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/pred_eb.sv
module pred_eb #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_stop,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         out_stop
);
    logic         vld_q;
    logic [W-1:0] dat_q;

    assign in_stop   = vld_q & out_stop;
    assign out_valid = vld_q;
    assign out_data  = dat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            dat_q <= '0;
        end else if (!in_stop) begin
            vld_q <= in_valid;
            if (in_valid)
                dat_q <= in_data;
        end
    end

    // R7: a stalled token is held unchanged
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_stop) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/pred_fork.sv
module pred_fork #(
    parameter int ND = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          src_valid,
    output logic          src_stop,
    input  logic [ND-1:0] dst_en,
    output logic [ND-1:0] dst_valid,
    input  logic [ND-1:0] dst_stop
);
    logic [ND-1:0] done_q;
    logic [ND-1:0] acc;
    logic          all_done;

    assign dst_valid = {ND{src_valid}} & dst_en & ~done_q;
    assign acc       = dst_valid & ~dst_stop;
    assign all_done  = &(~dst_en | done_q | acc);
    assign src_stop  = src_valid & ~all_done;

    always_ff @(posedge clk) begin
        if (rst)
            done_q <= '0;
        else if (src_valid && all_done)
            done_q <= '0;
        else if (src_valid)
            done_q <= done_q | acc;
    end

    // R6: a destination that took its copy is not offered the same token again
    for (genvar d = 0; d < ND; d++) begin : g_once
        p_once_r6: assert property (@(posedge clk) disable iff (rst)
            (src_valid && acc[d] && src_stop) |=> !dst_valid[d]);
    end

endmodule

// File: rtl/pred_lu.sv
module pred_lu
    import pred_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] op,
    input  logic       a_valid,
    input  logic       a_data,
    output logic       a_stop,
    input  logic       b_valid,
    input  logic       b_data,
    output logic       b_stop,
    output logic       res_valid,
    output logic       res_data,
    input  logic       res_stop
);
    logic eb_stop;
    logic fire;
    logic result;

    assign fire   = a_valid & b_valid & ~eb_stop;
    assign a_stop = ~(b_valid & ~eb_stop);
    assign b_stop = ~(a_valid & ~eb_stop);
    assign result = pred_eval(op, a_data, b_data);

    pred_eb #(.W(1)) u_res (
        .clk      (clk),
        .rst      (rst),
        .in_valid (a_valid & b_valid),
        .in_data  (result),
        .in_stop  (eb_stop),
        .out_valid(res_valid),
        .out_data (res_data),
        .out_stop (res_stop)
    );

    // R5: a result appears only after both operands were present
    p_fire_both_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(res_valid) |-> $past(a_valid && b_valid));

    // R4: the registered result matches the operation on the consumed operands
    p_result_r4: assert property (@(posedge clk) disable iff (rst)
        $past(fire && !rst) |-> (res_valid &&
            res_data == pred_eval($past(op), $past(a_data), $past(b_data))));

endmodule

// File: rtl/pred_tile.sv
module pred_tile
    import pred_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NPORT*ROUTE_W-1:0] cfg_route,
    input  logic [OPSEL_W-1:0]       cfg_opa,
    input  logic [OPSEL_W-1:0]       cfg_opb,
    input  logic [1:0]               cfg_op,
    input  logic [NPORT-1:0]         in_valid,
    input  logic [NPORT-1:0]         in_data,
    output logic [NPORT-1:0]         in_stop,
    output logic [NPORT-1:0]         out_valid,
    output logic [NPORT-1:0]         out_data,
    input  logic [NPORT-1:0]         out_stop
);
    logic [NSRC-1:0]  dsel [NDST];
    logic [NSRC-1:0]  src_valid;
    logic [NSRC-1:0]  src_data;
    logic [NDST-1:0]  fv [NSRC];
    logic [NDST-1:0]  dvalid;
    logic [NDST-1:0]  ddata;
    logic [NPORT-1:0] ostop;
    logic             stop_a;
    logic             stop_b;
    logic             lu_valid;
    logic             lu_data;
    logic             lu_stop;

    assign src_valid = {lu_valid, in_valid};
    assign src_data  = {lu_data,  in_data};

    // destination source selection
    for (genvar d = 0; d < NPORT; d++) begin : g_rsel
        assign dsel[d] = route_onehot(cfg_route[d*ROUTE_W +: ROUTE_W], d);
    end
    assign dsel[OPA_IDX] = opnd_onehot(cfg_opa);
    assign dsel[OPB_IDX] = opnd_onehot(cfg_opb);

    // one fork per source
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        logic [NDST-1:0] col;
        always_comb begin
            for (int d = 0; d < NDST; d++)
                col[d] = dsel[d][s];
        end
        if (s < NPORT) begin : g_in
            logic [NDST-1:0] fvl;
            pred_fork #(.ND(NDST)) u_fork (
                .clk      (clk),
                .rst      (rst),
                .src_valid(src_valid[s]),
                .src_stop (in_stop[s]),
                .dst_en   (col),
                .dst_valid(fvl),
                .dst_stop ({stop_b, stop_a, ostop})
            );
            assign fv[s] = fvl;
        end else begin : g_lu
            logic [NPORT-1:0] fvl;
            pred_fork #(.ND(NPORT)) u_fork (
                .clk      (clk),
                .rst      (rst),
                .src_valid(src_valid[s]),
                .src_stop (lu_stop),
                .dst_en   (col[NPORT-1:0]),
                .dst_valid(fvl),
                .dst_stop (ostop)
            );
            assign fv[s] = {2'b00, fvl};
        end
    end

    // destination gather
    always_comb begin
        for (int d = 0; d < NDST; d++) begin
            dvalid[d] = 1'b0;
            for (int s = 0; s < NSRC; s++)
                dvalid[d] = dvalid[d] | fv[s][d];
            ddata[d] = |(dsel[d] & src_data);
        end
    end

    // registered output ports
    for (genvar p = 0; p < NPORT; p++) begin : g_out
        pred_eb #(.W(1)) u_oeb (
            .clk      (clk),
            .rst      (rst),
            .in_valid (dvalid[p]),
            .in_data  (ddata[p]),
            .in_stop  (ostop[p]),
            .out_valid(out_valid[p]),
            .out_data (out_data[p]),
            .out_stop (out_stop[p])
        );

        // R3: an output with no legal source never presents a token
        p_off_r3: assert property (@(posedge clk) disable iff (rst)
            (dsel[p] == '0 && $past(dsel[p] == '0)) |-> !out_valid[p]);
    end

    pred_lu u_lu (
        .clk      (clk),
        .rst      (rst),
        .op       (cfg_op),
        .a_valid  (dvalid[OPA_IDX]),
        .a_data   (ddata[OPA_IDX]),
        .a_stop   (stop_a),
        .b_valid  (dvalid[OPB_IDX]),
        .b_data   (ddata[OPB_IDX]),
        .b_stop   (stop_b),
        .res_valid(lu_valid),
        .res_data (lu_data),
        .res_stop (lu_stop)
    );

endmodule

// File: tb/tb_pred_tile.sv
module tb_pred_tile;

    logic        clk = 1'b0;
    logic        rst;
    logic [19:0] cfg_route;
    logic [2:0]  cfg_opa, cfg_opb;
    logic [1:0]  cfg_op;
    logic [4:0]  in_valid, in_data, in_stop;
    logic [4:0]  out_valid, out_data, out_stop;

    int checks   = 0;
    int failures = 0;

    always #4 clk = ~clk;

    pred_tile dut (
        .clk(clk), .rst(rst), .cfg_route(cfg_route), .cfg_opa(cfg_opa),
        .cfg_opb(cfg_opb), .cfg_op(cfg_op), .in_valid(in_valid),
        .in_data(in_data), .in_stop(in_stop), .out_valid(out_valid),
        .out_data(out_data), .out_stop(out_stop)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic eval(input int op, input logic a, input logic b);
        if (op == 0) return a & b;
        if (op == 1) return a | b;
        if (op == 2) return a ^ b;
        return a;
    endfunction

    task automatic idle_cfg();
        cfg_route = '0; cfg_opa = '0; cfg_opb = '0; cfg_op = '0;
        in_valid = '0; in_data = '0; out_stop = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle_cfg();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(out_valid == 5'd0, "R1 reset out_valid", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 5'd0, "R1 post-reset out_valid", int'(out_valid), 0);
        chk(in_stop == 5'd0, "R1 post-reset in_stop", int'(in_stop), 0);

        // R2 / R3 route sweep over every output and code
        for (int o = 0; o < 5; o++) begin
            for (int code = 0; code < 16; code++) begin
                for (int pi = 0; pi < 2; pi++) begin
                    logic [4:0] pat;
                    logic legal;
                    int srcp;
                    pat = (pi == 0) ? 5'b01101 : 5'b10010;
                    srcp = code - 1;
                    legal = (code >= 1 && code <= 5) && !(srcp < 4 && srcp == o);
                    @(negedge clk);
                    idle_cfg();
                    cfg_route[o*4 +: 4] = 4'(code);
                    in_valid = 5'h1f; in_data = pat;
                    #1;
                    chk(in_stop == 5'd0, "R3 no input stalled", int'(in_stop), 0);
                    @(negedge clk);
                    in_valid = '0;
                    if (legal) begin
                        chk(out_valid[o] == 1'b1, "R2 routed valid", int'(out_valid[o]), 1);
                        chk(out_data[o] == pat[srcp], "R2 routed data", int'(out_data[o]), int'(pat[srcp]));
                    end else begin
                        chk(out_valid[o] == 1'b0, "R3 disabled output", int'(out_valid[o]), 0);
                    end
                    @(negedge clk);
                end
            end
        end

        // R4 / R5 logic unit sweep
        for (int a = 1; a <= 5; a++) begin
            for (int b = 1; b <= 5; b++) begin
                for (int op = 0; op < 4; op++) begin
                    for (int p = 0; p < 32; p++) begin
                        logic [4:0] pat;
                        logic exp;
                        pat = 5'(p);
                        exp = eval(op, pat[a-1], pat[b-1]);
                        @(negedge clk);
                        idle_cfg();
                        cfg_route[16 +: 4] = 4'd6;
                        cfg_opa = 3'(a); cfg_opb = 3'(b); cfg_op = 2'(op);
                        in_valid = 5'h1f; in_data = pat;
                        @(negedge clk);
                        in_valid = '0;
                        chk(out_valid[4] == 1'b0, "R5 no result after one edge", int'(out_valid[4]), 0);
                        @(negedge clk);
                        chk(out_valid[4] == 1'b1, "R5 result after two edges", int'(out_valid[4]), 1);
                        chk(out_data[4] == exp, "R4 logic result", int'(out_data[4]), int'(exp));
                        @(negedge clk);
                    end
                end
            end
        end

        // R5 lone operand held
        @(negedge clk);
        idle_cfg();
        cfg_route[16 +: 4] = 4'd6; cfg_opa = 3'd1; cfg_opb = 3'd2; cfg_op = 2'd0;
        in_valid[0] = 1'b1; in_data[0] = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(out_valid[4] == 1'b0, "R5 lone operand no result", int'(out_valid[4]), 0);
            chk(in_stop[0] == 1'b1, "R5 lone operand held", int'(in_stop[0]), 1);
        end
        in_valid[1] = 1'b1; in_data[1] = 1'b1;
        #1;
        chk(in_stop[1:0] == 2'b00, "R5 pair accepted", int'(in_stop[1:0]), 0);
        @(negedge clk);
        in_valid = '0;
        chk(out_valid[4] == 1'b0, "R5 paired no early result", int'(out_valid[4]), 0);
        @(negedge clk);
        chk(out_valid[4] == 1'b1 && out_data[4] == 1'b1, "R5 paired result", int'({out_valid[4], out_data[4]}), 3);
        @(negedge clk);

        // R6 fork release
        @(negedge clk);
        idle_cfg();
        cfg_route[4 +: 4] = 4'd1; cfg_route[8 +: 4] = 4'd1;
        out_stop = 5'b00100;
        in_valid[0] = 1'b1; in_data[0] = 1'b0;
        #1;
        chk(in_stop[0] == 1'b0, "R6 first token taken by both", int'(in_stop[0]), 0);
        @(negedge clk);
        in_valid = '0;
        chk(out_valid[2:1] == 2'b11, "R6 both copies", int'(out_valid[2:1]), 3);
        @(negedge clk);
        in_valid[0] = 1'b1; in_data[0] = 1'b1;
        #1;
        chk(in_stop[0] == 1'b1, "R6 source held by stalled branch", int'(in_stop[0]), 1);
        @(negedge clk);
        chk(out_valid[1] == 1'b1 && out_data[1] == 1'b1, "R6 free branch got token", int'({out_valid[1], out_data[1]}), 3);
        chk(out_valid[2] == 1'b1 && out_data[2] == 1'b0, "R6 stalled branch keeps old", int'({out_valid[2], out_data[2]}), 2);
        chk(in_stop[0] == 1'b1, "R6 source still held", int'(in_stop[0]), 1);
        @(negedge clk);
        chk(out_valid[1] == 1'b0, "R6 no duplicate", int'(out_valid[1]), 0);
        chk(in_stop[0] == 1'b1, "R6 source held until all", int'(in_stop[0]), 1);
        out_stop = '0;
        #1;
        chk(in_stop[0] == 1'b0, "R6 source released", int'(in_stop[0]), 0);
        @(negedge clk);
        in_valid = '0;
        chk(out_valid[2] == 1'b1 && out_data[2] == 1'b1, "R6 late branch token", int'({out_valid[2], out_data[2]}), 3);
        chk(out_valid[1] == 1'b0, "R6 no extra copy", int'(out_valid[1]), 0);
        @(negedge clk);
        chk(out_valid[2] == 1'b0, "R6 drained", int'(out_valid[2]), 0);

        // R7 back-pressure
        @(negedge clk);
        idle_cfg();
        cfg_route[8 +: 4] = 4'd1;
        out_stop = 5'b00100;
        in_valid[0] = 1'b1; in_data[0] = 1'b1;
        @(negedge clk);
        in_data[0] = 1'b0;
        chk(out_valid[2] == 1'b1 && out_data[2] == 1'b1, "R7 first token", int'({out_valid[2], out_data[2]}), 3);
        #1;
        chk(in_stop[0] == 1'b1, "R7 full and stopped", int'(in_stop[0]), 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(out_valid[2] == 1'b1 && out_data[2] == 1'b1, "R7 held stable", int'({out_valid[2], out_data[2]}), 3);
            chk(in_stop[0] == 1'b1, "R7 upstream stopped", int'(in_stop[0]), 1);
        end
        out_stop = '0;
        #1;
        chk(in_stop[0] == 1'b0, "R7 stop released", int'(in_stop[0]), 0);
        @(negedge clk);
        in_valid = '0;
        chk(out_valid[2] == 1'b1 && out_data[2] == 1'b0, "R7 second token", int'({out_valid[2], out_data[2]}), 2);
        @(negedge clk);

        // R8 throughput west -> east
        @(negedge clk);
        idle_cfg();
        cfg_route[4 +: 4] = 4'd4;
        begin
            logic [7:0] seq;
            seq = 8'b10110010;
            for (int i = 0; i < 8; i++) begin
                in_valid[3] = 1'b1; in_data[3] = seq[i];
                #1;
                chk(in_stop[3] == 1'b0, "R8 no stall", int'(in_stop[3]), 0);
                @(negedge clk);
                chk(out_valid[1] == 1'b1 && out_data[1] == seq[i], "R8 streamed token",
                    int'({out_valid[1], out_data[1]}), int'({1'b1, seq[i]}));
            end
            in_valid = '0;
            @(negedge clk);
            chk(out_valid[1] == 1'b0, "R8 stream ends", int'(out_valid[1]), 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule